// File: doc/BRIEF.md
# Burst Frame Pusher for Rotated Video

This block sits between a frame store that holds a rotated picture and a downstream scaler. It stays idle, with vertical sync held high, until the writer signals that a whole frame is in the store. It then reads that frame out in one compressed burst. The burst is row-major and runs at four or eight times the source pixel rate. The block drives data enable, horizontal sync and vertical sync for the burst, all in step with the pixel data.

When the last line of the burst is done, vertical sync goes high again and stays high until the next complete frame arrives. The output therefore delivers one frame per source frame, with little latency. A frame-complete pulse that arrives while a burst is running is remembered, and the next burst starts as soon as the minimum sync hold has passed.

The readout clock enable `ce` runs at eight times the source pixel rate. In 8x mode the burst advances one pixel on every enabled cycle. In 4x mode it advances one pixel on every second enabled cycle.

Top module: `burst_frame_pusher`

## Requirements
- R1: While reset is held and right after it, `vs_o` is 1, `de_o` is 0 and `hs_o` is 0.
- R2: No burst starts without a frame-complete pulse. `vs_o` stays 1 and `de_o` stays 0 for as long as none arrives.
- R3: Assume `ce` is continuous and vertical sync has already been held for VS_MIN ticks. A one-cycle pulse on `frame_done` sampled at edge k then gives the first `de_o`=1 after edge k+RD_LAT+1, and `de_o` is still 0 after edge k+RD_LAT.
- R4: Each burst has V_LINES lines. Every line, the first one included, has exactly H_ACT active pixels.
- R5: `spd_x8`=1 holds each pixel for one enabled tick and `spd_x8`=0 holds it for two. The value is taken when the burst starts. A change in the middle of a burst has no effect on that burst, so a burst lasts V_LINES*(H_ACT+H_BLANK) pixel times.
- R6: Lines are separated by H_BLANK pixel times with `de_o`=0, where H_BLANK is raised to at least 5. `hs_o` is 1 for the first HS_W pixel times of each blank and 0 at every other point of the burst.
- R7: The read address is 0 at the start of each burst and goes up by one with each pixel step taken while enable is high. `pix_o` is the store word read at that address, aligned with `de_o`/`hs_o`/`vs_o` on the same tick, so pixel n of the frame in row-major order shows word n.
- R8: After the blank that follows the last line, `vs_o` goes to 1 and stays there until the next burst. Each sync hold lasts at least VS_MIN enabled ticks.
- R9: A `frame_done` pulse during a burst is latched. The next burst then starts after exactly VS_MIN ticks of sync hold. Several pulses during one burst give one extra burst only.
- R10: A burst at 4x must fit inside one source frame period of SRC_FRAME_PIX source pixels, which is SRC_FRAME_PIX*8 enabled ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce | input | 1 | Readout enable, eight times the source pixel rate |
| spd_x8 | input | 1 | 1 selects 8x burst speed, 0 selects 4x |
| frame_done | input | 1 | Pulse: a complete frame is in the store |
| rd_addr | output | ADDR_W | Frame store read address |
| rd_data | input | DW | Store read data, RD_LAT enabled ticks after the address |
| pix_o | output | DW | Output pixel |
| de_o | output | 1 | Output data enable |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |

## Verification
A wrong pixel or line counter shows up within one line as an active run of the wrong length, or as a blank gap or sync pulse of the wrong width. A wrong address counter shows up on the very next enabled pixel as a data word that does not match the row-major index. A pending flag that is lost or duplicated shows up as a missing or extra burst during the following sync hold. A speed setting that is latched at the wrong time changes the pixel repeat count inside the same burst.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef enum logic {ST_HOLD = 1'b0, ST_BURST = 1'b1} fp_state_e;

  localparam int unsigned FP_MIN_BLANK = 5;
  localparam int unsigned FP_BASE_MULT = 8;

  function automatic int unsigned fp_blank_eff(input int unsigned blank);
    return (blank < FP_MIN_BLANK) ? FP_MIN_BLANK : blank;
  endfunction

  function automatic int unsigned fp_line_len(input int unsigned act, input int unsigned blank);
    return act + fp_blank_eff(blank);
  endfunction

  function automatic int unsigned fp_burst_steps(input int unsigned act, input int unsigned blank,
                                                 input int unsigned lines);
    return lines * fp_line_len(act, blank);
  endfunction

  function automatic int unsigned fp_tick_mult(input logic x8);
    return x8 ? 1 : 2;
  endfunction

  function automatic int unsigned fp_src_ticks(input int unsigned src_pix);
    return src_pix * FP_BASE_MULT;
  endfunction

endpackage

// File: rtl/fp_ctrl.sv
module fp_ctrl
  import fp_pkg::*;
#(
  parameter int unsigned VS_MIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic frame_done,
  input  logic burst_end,
  output logic start,
  output logic busy,
  output logic pend
);
  localparam int unsigned VS_EFF = (VS_MIN < 1) ? 1 : VS_MIN;
  localparam int unsigned CW     = $clog2(VS_EFF + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(VS_EFF - 1);

  fp_state_e     state_q;
  logic [CW-1:0] hold_cnt_q;
  logic          hold_done;

  assign hold_done = (hold_cnt_q == HOLD_LAST);
  assign start     = (state_q == ST_HOLD) && ce && pend && hold_done;
  assign busy      = (state_q == ST_BURST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HOLD;
      hold_cnt_q <= '0;
      pend       <= 1'b0;
    end else begin
      pend <= frame_done | (pend & ~start);
      if (start) begin
        state_q <= ST_BURST;
      end else if (burst_end) begin
        state_q    <= ST_HOLD;
        hold_cnt_q <= '0;
      end else if ((state_q == ST_HOLD) && ce && !hold_done) begin
        hold_cnt_q <= hold_cnt_q + 1'b1;
      end
    end
  end

  assert_start_needs_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend));

  assert_end_leaves_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !busy);

endmodule

// File: rtl/fp_timing.sv
module fp_timing
  import fp_pkg::*;
#(
  parameter int unsigned H_ACT   = 224,
  parameter int unsigned V_LINES = 256,
  parameter int unsigned H_BLANK = 8,
  parameter int unsigned HS_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic spd_x8,
  input  logic start,
  input  logic busy,
  output logic stp,
  output logic de_i,
  output logic hs_i,
  output logic burst_end
);
  localparam int unsigned LINE_LEN = fp_line_len(H_ACT, H_BLANK);
  localparam int unsigned BLANK    = fp_blank_eff(H_BLANK);
  localparam int unsigned HS_EFF   = (HS_W > BLANK) ? BLANK : HS_W;
  localparam int unsigned HW       = $clog2(LINE_LEN + 1);
  localparam int unsigned VW       = $clog2(V_LINES + 1);
  localparam logic [HW-1:0] H_LAST  = HW'(LINE_LEN - 1);
  localparam logic [HW-1:0] H_ACTV  = HW'(H_ACT);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACT + HS_EFF);
  localparam logic [VW-1:0] V_LAST  = VW'(V_LINES - 1);

  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          phase_q;
  logic          spd_q;
  logic          line_end;

  assign stp       = ce && busy && (spd_q || phase_q);
  assign line_end  = stp && (hcnt_q == H_LAST);
  assign burst_end = line_end && (vcnt_q == V_LAST);
  assign de_i      = busy && (hcnt_q < H_ACTV);
  assign hs_i      = busy && (hcnt_q >= H_ACTV) && (hcnt_q < HS_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      phase_q <= 1'b0;
      spd_q   <= 1'b1;
    end else if (start) begin
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      phase_q <= 1'b0;
      spd_q   <= spd_x8;
    end else begin
      if (ce && busy) phase_q <= ~phase_q;
      if (line_end) begin
        hcnt_q <= '0;
        vcnt_q <= burst_end ? '0 : vcnt_q + 1'b1;
      end else if (stp) begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assert_line_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !burst_end && !start) |=> (hcnt_q == '0) && (vcnt_q == $past(vcnt_q) + 1'b1));

  assert_speed_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(spd_q));

endmodule

// File: rtl/fp_addr.sv
module fp_addr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stp,
  input  logic              de_i,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr <= '0;
    else if (start)      addr <= '0;
    else if (stp && de_i) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/fp_align.sv
module fp_align #(
  parameter int unsigned RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic de_i,
  input  logic hs_i,
  input  logic vs_i,
  output logic de_o,
  output logic hs_o,
  output logic vs_o
);
  generate
    if (RD_LAT == 0) begin : g_direct
      assign de_o = de_i;
      assign hs_o = hs_i;
      assign vs_o = vs_i;
    end else begin : g_pipe
      logic [2:0] stage_q [RD_LAT];
      for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  stage_q[s] <= 3'b100;
          else if (ce) stage_q[s] <= (s == 0) ? {vs_i, hs_i, de_i} : stage_q[(s == 0) ? 0 : s - 1];
        end
      end
      assign {vs_o, hs_o, de_o} = stage_q[RD_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/burst_frame_pusher.sv
module burst_frame_pusher
  import fp_pkg::*;
#(
  parameter int unsigned H_ACT         = 224,
  parameter int unsigned V_LINES       = 256,
  parameter int unsigned H_BLANK       = 8,
  parameter int unsigned HS_W          = 4,
  parameter int unsigned VS_MIN        = 16,
  parameter int unsigned RD_LAT        = 2,
  parameter int unsigned DW            = 24,
  parameter int unsigned SRC_FRAME_PIX = 101376,
  localparam int unsigned ADDR_W       = (H_ACT * V_LINES > 1) ? $clog2(H_ACT * V_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              spd_x8,
  input  logic              frame_done,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     pix_o,
  output logic              de_o,
  output logic              hs_o,
  output logic              vs_o
);
  localparam int unsigned SRC_TICKS  = fp_src_ticks(SRC_FRAME_PIX);
  localparam int unsigned BURST_MAX  = fp_burst_steps(H_ACT, H_BLANK, V_LINES) * fp_tick_mult(1'b0);
  localparam bit          FITS       = (BURST_MAX <= SRC_TICKS);

  logic start, busy, pend, stp, de_i, hs_i, burst_end;

  fp_ctrl #(.VS_MIN(VS_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .frame_done(frame_done),
    .burst_end(burst_end), .start(start), .busy(busy), .pend(pend)
  );

  fp_timing #(.H_ACT(H_ACT), .V_LINES(V_LINES), .H_BLANK(H_BLANK), .HS_W(HS_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .ce(ce), .spd_x8(spd_x8), .start(start), .busy(busy),
    .stp(stp), .de_i(de_i), .hs_i(hs_i), .burst_end(burst_end)
  );

  fp_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .stp(stp), .de_i(de_i), .addr(rd_addr)
  );

  fp_align #(.RD_LAT(RD_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .ce(ce), .de_i(de_i), .hs_i(hs_i), .vs_i(!busy),
    .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
  );

  assign pix_o = rd_data;

  // Window counters for the checks below
  logic [31:0] burst_ticks_q;
  logic [31:0] hold_ticks_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_ticks_q <= '0;
      hold_ticks_q  <= '0;
    end else begin
      if (start)           burst_ticks_q <= '0;
      else if (busy && ce) burst_ticks_q <= burst_ticks_q + 1'b1;
      if (busy)             hold_ticks_q <= '0;
      else if (ce && !start) hold_ticks_q <= hold_ticks_q + 1'b1;
    end
  end

  assert_burst_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (FITS && (burst_ticks_q < SRC_TICKS)));

  assert_hold_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (hold_ticks_q + 1 >= VS_MIN));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stp && de_i) && !$past(start)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  assert_addr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rd_addr == '0));

endmodule

// File: tb/burst_frame_pusher_tb.sv
module burst_frame_pusher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H_ACT = 6, V_LINES = 4, H_BLANK = 5, HS_W = 2, VS_MIN = 3, RD_LAT = 2, DW = 12;
  localparam int SRC_FRAME_PIX = 12;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0, ce = 1, spd_x8 = 1, frame_done = 0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data, pix_o;
  logic de_o, hs_o, vs_o;

  int checks = 0, fails = 0;
  int ce_mode = 0, ce_div = 0, cur_mult = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_frame_pusher #(.H_ACT(H_ACT), .V_LINES(V_LINES), .H_BLANK(H_BLANK), .HS_W(HS_W),
    .VS_MIN(VS_MIN), .RD_LAT(RD_LAT), .DW(DW), .SRC_FRAME_PIX(SRC_FRAME_PIX)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .spd_x8(spd_x8), .frame_done(frame_done),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_o(pix_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o));

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 7 + 3);
  endfunction

  // store model: RD_LAT enabled ticks of read latency
  logic [DW-1:0] mem_pipe [RD_LAT];
  always @(posedge clk) if (ce) begin
    mem_pipe[0] <= pat(int'(rd_addr));
    for (int i = 1; i < RD_LAT; i++) mem_pipe[i] <= mem_pipe[i-1];
  end
  assign rd_data = mem_pipe[RD_LAT-1];

  always @(negedge clk) begin
    ce_div = (ce_div + 1) % 3;
    ce <= (ce_mode == 0) ? 1'b1 : (ce_div == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  logic tick = 0;
  always @(posedge clk) tick <= ce;
  bit mon_en = 0, prev_vs = 1;
  int frames = 0, vs_run = 0, last_vs_run = 0, mult_q = 1, burst_ticks = 0;
  int idx = 0, rep = 0, line_de = 0, blank = 0, lines = 0;
  int data_err = 0, len_err = 0, blank_err = 0, hs_err = 0;

  always @(negedge clk) if (mon_en && tick) begin
    if (vs_o) begin
      if (!prev_vs) begin
        if (blank != H_BLANK * mult_q) blank_err++;
        frames++;
        check(lines == V_LINES, "R4 line count", lines, V_LINES);
        check(len_err == 0, "R4 active length errors", len_err, 0);
        check(data_err == 0 && idx == H_ACT * V_LINES, "R7 data/index", idx, H_ACT * V_LINES);
        check(blank_err == 0 && hs_err == 0, "R6 blank/hs errors", blank_err + hs_err, 0);
        check(burst_ticks == V_LINES * (H_ACT + H_BLANK) * mult_q, "R5 burst ticks",
              burst_ticks, V_LINES * (H_ACT + H_BLANK) * mult_q);
        check(burst_ticks <= SRC_FRAME_PIX * 8, "R10 burst fits", burst_ticks, SRC_FRAME_PIX * 8);
      end
      vs_run++;
    end else begin
      if (prev_vs) begin
        last_vs_run = vs_run;
        check(vs_run >= VS_MIN, "R8 vs hold", vs_run, VS_MIN);
        vs_run = 0; mult_q = cur_mult; burst_ticks = 0; idx = 0; rep = 0;
        line_de = 0; blank = 0; lines = 0; data_err = 0; len_err = 0; blank_err = 0; hs_err = 0;
      end
      burst_ticks++;
      if (de_o) begin
        if (line_de == 0 && lines > 0 && blank != H_BLANK * mult_q) blank_err++;
        if (pix_o != pat(idx)) data_err++;
        if (hs_o) hs_err++;
        rep++;
        if (rep == mult_q) begin idx++; rep = 0; end
        line_de++; blank = 0;
      end else begin
        if (line_de > 0) begin
          if (line_de != H_ACT * mult_q) len_err++;
          lines++; line_de = 0;
        end
        if (hs_o != (blank < HS_W * mult_q)) hs_err++;
        blank++;
      end
    end
    prev_vs = vs_o;
  end

  task automatic pulse_fd();
    @(negedge clk) frame_done = 1;
    @(negedge clk) frame_done = 0;
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check(vs_o == 1, "R1 vs in reset", vs_o, 1);
    check(de_o == 0 && hs_o == 0, "R1 de/hs in reset", {de_o, hs_o}, 0);
    rst_n = 1;
    @(negedge clk);
    check(vs_o == 1 && de_o == 0, "R1 after reset", {vs_o, de_o}, 2);
    check(rd_addr == 0, "R7 addr after reset", rd_addr, 0);
    mon_en = 1;

    // R2: no frame-complete, no burst
    repeat (200) @(negedge clk);
    check(frames == 0 && vs_o == 1, "R2 idle without frame", frames, 0);
    check(de_o == 0, "R2 de idle", de_o, 0);

    // R3: latency, 8x, continuous ce
    cur_mult = 1; spd_x8 = 1;
    @(negedge clk) frame_done = 1;
    @(posedge clk);
    @(negedge clk) frame_done = 0;
    repeat (RD_LAT) @(posedge clk);
    @(negedge clk) check(de_o == 0, "R3 de before latency", de_o, 0);
    @(posedge clk);
    @(negedge clk) check(de_o == 1, "R3 first de", de_o, 1);
    wait_frames(1);

    // R5: 4x, speed pin flipped mid-burst must not matter
    repeat (20) @(negedge clk);
    cur_mult = 2; spd_x8 = 0;
    pulse_fd();
    repeat (30) @(negedge clk);
    spd_x8 = 1;
    wait_frames(2);
    cur_mult = 1;

    // sparse enable, 8x then 4x
    ce_mode = 1;
    repeat (30) @(negedge clk);
    pulse_fd();
    wait_frames(3);
    repeat (30) @(negedge clk);
    cur_mult = 2; spd_x8 = 0;
    pulse_fd();
    wait_frames(4);
    ce_mode = 0; cur_mult = 1; spd_x8 = 1;

    // R9: pulses during burst latched, collapsed to one
    repeat (30) @(negedge clk);
    f0 = frames;
    pulse_fd();
    repeat (10) @(negedge clk);
    pulse_fd();
    repeat (5) @(negedge clk);
    pulse_fd();
    wait_frames(f0 + 2);
    repeat (300) @(negedge clk);
    check(frames == f0 + 2, "R9 one extra burst", frames, f0 + 2);
    check(last_vs_run == VS_MIN, "R9 restart after VS_MIN", last_vs_run, VS_MIN);
    check(vs_o == 1 && de_o == 0, "R8 vs held after burst", {vs_o, de_o}, 2);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule